// File: doc/BRIEF.md
# Prioritized Interrupt Dispatcher

This block arbitrates interrupts for a small 8-bit processor core. Five peripheral sources raise one-cycle request pulses. The block latches each pulse into a request register. A separate enable register, written by software, masks the sources. While the core's master interrupt enable is set, the block picks the most urgent source that is both requested and enabled. It then clears that one request bit, drops the master enable and hands the core a fixed service vector with a one-cycle strobe.

Both registers are reached through a simple byte-wide register port at fixed addresses. The block also drives a wake line, independent of the master enable, so that a halted core can resume as soon as any enabled request is waiting. Instruction flow, stack handling and the peripherals themselves are outside this block.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the request and enable registers and the master enable are 0, `dispatch_o` and `wake_o` are 0, and a read of the request address returns 0xE0.
- R2: A write to address 0xFF0F loads request bits 4:0, and a write to 0xFFFF loads enable bits 4:0. Reads of 0xFF0F return bits 7:5 as 1, reads of 0xFFFF return bits 7:5 as 0, and writes to any other address change neither register.
- R3: Request/enable bit positions are 0 vertical blank, 1 LCD status, 2 timer, 3 serial, 4 joypad. The lowest position that is both requested and enabled has the highest priority.
- R4: The vector for bit position k is 0x40 + 8*k, so the vectors are 0x40, 0x48, 0x50, 0x58 and 0x60.
- R5: No dispatch occurs while the master enable is 0, or while no source has both its request and enable bits at 1.
- R6: A dispatch clears only the serviced request bit. The enable register is left unchanged.
- R7: A dispatch clears the master enable. `dispatch_o` is high for exactly one cycle.
- R8: A request pulse that arrives in the dispatch cycle is kept. A pulse on another bit sets that bit, and a pulse on the serviced bit leaves that bit set.
- R9: `wake_o` is 1 exactly when (request AND enable) is nonzero, whatever the state of the master enable.
- R10: `dispatch_o` and `vector_o` become valid in the cycle after the clock edge at which the master enable is 1 and an enabled request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 5 | One-cycle request pulses from the sources |
| ime_set_i | input | 1 | Set the master enable |
| ime_clr_i | input | 1 | Clear the master enable (wins over set) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ime_o | output | 1 | Current master enable |
| wake_o | output | 1 | An enabled request is pending |
| dispatch_o | output | 1 | One-cycle dispatch strobe |
| vector_o | output | 8 | Service vector, valid with the strobe |

## Verification
Register writes and request pulses appear on `reg_rdata_o` and `wake_o` one edge after they are driven, because both outputs decode the registers combinationally. A master-enable set pulse takes one edge to reach `ime_o`. The dispatch strobe, the vector, the request-bit clear and the master-enable drop all appear together one edge later. The bench drives every input on the falling edge and samples on the next falling edge after the edge at which each result is due. It then takes one more sample to confirm that the strobe has fallen again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_N     = 5;
  localparam logic [7:0]  VEC_BASE  = 8'h40;
  localparam logic [7:0]  VEC_STEP  = 8'h08;
  localparam logic [15:0] REQ_ADDR  = 16'hFF0F;
  localparam logic [15:0] EN_ADDR   = 16'hFFFF;

  function automatic logic [7:0] vec_of(input logic [7:0] idx);
    return VEC_BASE + idx * VEC_STEP;
  endfunction
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned N     = 5,
  localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o
);
  // fixed priority: lowest index wins
  for (genvar i = 0; i < N; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant_o[i] = pend_i[i];
    end else begin : g_rest
      assign grant_o[i] = pend_i[i] & ~(|pend_i[i-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned N        = 5,
  parameter logic [15:0] REQ_ADDR = 16'hFF0F,
  parameter logic [15:0] EN_ADDR  = 16'hFFFF,
  localparam int unsigned PAD     = 8 - N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [15:0]  addr_i,
  input  logic [7:0]   wdata_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] en_o,
  output logic [7:0]   rdata_o
);
  logic [N-1:0] req_q, req_d, en_q, en_d;
  logic         req_hit, en_hit;

  assign req_hit = we_i && (addr_i == REQ_ADDR);
  assign en_hit  = we_i && (addr_i == EN_ADDR);

  // pulses are ORed last so a same-cycle set beats the dispatch clear
  always_comb begin
    req_d = req_hit ? wdata_i[N-1:0] : (req_q & ~clr_i);
    req_d = req_d | set_i;
    en_d  = en_hit ? wdata_i[N-1:0] : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      req_q <= req_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    if (addr_i == REQ_ADDR)     rdata_o = {{PAD{1'b1}}, req_q};
    else if (addr_i == EN_ADDR) rdata_o = {{PAD{1'b0}}, en_q};
    else                        rdata_o = 8'h00;
  end

  assign req_o = req_q;
  assign en_o  = en_q;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IRQ_N-1:0]  req_set_i,
  input  logic              ime_set_i,
  input  logic              ime_clr_i,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              ime_o,
  output logic              wake_o,
  output logic              dispatch_o,
  output logic [7:0]        vector_o
);
  localparam int unsigned IW = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;

  logic [IRQ_N-1:0] req, en, pend, grant, clr;
  logic [IW-1:0]    idx;
  logic             ime_q, fire, disp_q;
  logic [7:0]       vec_q;

  irq_regs #(.N(IRQ_N), .REQ_ADDR(REQ_ADDR), .EN_ADDR(EN_ADDR)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .set_i   (req_set_i),
    .clr_i   (clr),
    .req_o   (req),
    .en_o    (en),
    .rdata_o (reg_rdata_o)
  );

  assign pend = req & en;

  irq_prio_sel #(.N(IRQ_N)) i_sel (
    .pend_i  (pend),
    .grant_o (grant),
    .idx_o   (idx)
  );

  assign wake_o = |pend;
  assign fire   = ime_q & wake_o;
  assign clr    = fire ? grant : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ime_q  <= 1'b0;
      disp_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      disp_q <= fire;
      if (fire) vec_q <= vec_of(8'(idx));
      if (fire || ime_clr_i) ime_q <= 1'b0;
      else if (ime_set_i)    ime_q <= 1'b1;
    end
  end

  assign ime_o      = ime_q;
  assign dispatch_o = disp_q;
  assign vector_o   = vec_q;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ime_o,
  input logic       wake_o,
  input logic       dispatch_o,
  input logic [7:0] vector_o
);
  // R7
  strobe_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |=> !dispatch_o);
  // R7
  ime_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |-> !ime_o);
  // R5
  no_dispatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ime_o && wake_o) |=> !dispatch_o);
  // R10
  dispatch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ime_o && wake_o) |=> dispatch_o);
  // R4
  vector_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |-> (vector_o inside {8'h40, 8'h48, 8'h50, 8'h58, 8'h60}));
endmodule

bind irq_dispatch irq_dispatch_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ime_o      (ime_o),
  .wake_o     (wake_o),
  .dispatch_o (dispatch_o),
  .vector_o   (vector_o)
);

// File: tb/test_irq_dispatch.sv
`timescale 1ns/1ps
module test_irq_dispatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] req_set = '0;
  logic       ime_set = 1'b0, ime_clr = 1'b0, we = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wdata = '0, rdata, vector;
  logic       ime, wake, dispatch;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  irq_dispatch i_irq_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .req_set_i(req_set),
    .ime_set_i(ime_set), .ime_clr_i(ime_clr),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ime_o(ime), .wake_o(wake),
    .dispatch_o(dispatch), .vector_o(vector)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #0.5 d = rdata;
  endtask

  // set ime, dispatch due one edge after ime is seen; mask pulses into that edge
  task automatic try_dispatch(input logic [4:0] mask, output logic got, output logic [7:0] v);
    @(negedge clk); ime_set = 1'b1;
    @(negedge clk); ime_set = 1'b0; req_set = mask;
    @(negedge clk); req_set = '0; got = dispatch; v = vector;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 dispatch", dispatch, 0);
    chk("R1 wake", wake, 0);
    chk("R1 ime", ime, 0);
    rd(16'hFF0F, d); chk("R1 req", d, 8'hE0);
    rd(16'hFFFF, d); chk("R1 en", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(16'hFF0F, 8'h0A); rd(16'hFF0F, d); chk("R2 req", d, 8'hEA);
    wr(16'hFFFF, 8'hF5); rd(16'hFFFF, d); chk("R2 en", d, 8'h15);
    wr(16'hFF10, 8'h1F); rd(16'hFF0F, d); chk("R2 other req", d, 8'hEA);
    rd(16'hFFFF, d); chk("R2 other en", d, 8'h15);
    wr(16'hFF0F, 8'h00); wr(16'hFFFF, 8'h00);
  endtask

  task automatic t_priority();
    logic g; logic [7:0] v, d;
    wr(16'hFFFF, 8'h1F); wr(16'hFF0F, 8'h1F);
    for (int k = 0; k < 5; k++) begin
      try_dispatch(5'h00, g, v);
      chk("R3 dispatch", g, 1);
      chk("R4 vector", v, 8'h40 + 8 * k);
      chk("R7 ime cleared", ime, 0);
      rd(16'hFF0F, d);
      chk("R6 one bit cleared", d, 8'hE0 | (8'h1F & ~((8'h02 << k) - 1)));
      chk("R7 strobe low", dispatch, 0);
    end
    rd(16'hFFFF, d); chk("R6 en kept", d, 8'h1F);
    wr(16'hFFFF, 8'h14); wr(16'hFF0F, 8'h1F);
    try_dispatch(5'h00, g, v);
    chk("R3 masked pick", v, 8'h50);
    wr(16'hFF0F, 8'h00);
  endtask

  task automatic t_gating();
    logic g; logic [7:0] v;
    wr(16'hFFFF, 8'h00); wr(16'hFF0F, 8'h1F);
    chk("R9 wake off", wake, 0);
    try_dispatch(5'h00, g, v);
    chk("R5 no enable", g, 0);
    @(negedge clk); ime_clr = 1'b1; @(negedge clk); ime_clr = 1'b0;
    wr(16'hFFFF, 8'h08);
    chk("R9 wake without ime", wake, 1);
    repeat (3) begin
      @(negedge clk); chk("R5 ime off", dispatch, 0);
    end
    wr(16'hFF0F, 8'h00); wr(16'hFFFF, 8'h00);
  endtask

  task automatic t_collide();
    logic g; logic [7:0] v, d;
    wr(16'hFFFF, 8'h03); wr(16'hFF0F, 8'h01);
    try_dispatch(5'h02, g, v);
    chk("R8 other bit vec", v, 8'h40);
    rd(16'hFF0F, d); chk("R8 other bit kept", d, 8'hE2);
    wr(16'hFF0F, 8'h01);
    try_dispatch(5'h01, g, v);
    chk("R8 same bit dispatch", g, 1);
    rd(16'hFF0F, d); chk("R8 same bit wins", d, 8'hE1);
    chk("R9 wake stays", wake, 1);
    wr(16'hFF0F, 8'h00);
    chk("R9 wake clears", wake, 0);
  endtask

  task automatic t_pulse_wake();
    @(negedge clk); req_set = 5'h04;
    @(negedge clk); req_set = '0;
    chk("R9 pulse no en", wake, 0);
    wr(16'hFFFF, 8'h04);
    chk("R9 pulse latched", wake, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_priority();
    t_gating();
    t_collide();
    t_pulse_wake();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end
endmodule